// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Register File

This block is the synchronous digital front end of a sixteen-channel, eight-bit voltage-output converter. A host drives a parallel port made of an eight-bit data bus, a four-bit channel address, active-low chip select, enable and load strobes, a read/write select and an active-low reset. Every channel keeps two ranks of storage. The first rank, the staging register, takes host data. The second rank, the code register, drives the converter. The sixteen code registers are presented side by side on one flat output vector. A code D corresponds to an analog level of D/256 of the reference, so 0xFF lies one step below full reference.

The host can stage one channel and then strobe load to update it alone. It can also stage every channel first and then update all sixteen together with a single load strobe. When select, enable, write and load are all active at once, staged data passes through to the code register with no further action. The staging registers can be read back over the same bus. The bidirectional bus is split into an input, an output and an output-enable. All strobes and the address and data inputs pass through a two-flop alignment stage before any decode, so a change at the pins takes effect on the third rising clock edge after it.

This block has no streaming data path, so it has no valid/ready handshake. All pins are plain level controls that the host holds for as long as it needs.

Top module: `dacfe_top`

## Requirements
- R1: The address value n (0 to 15, binary) selects channel n. The code of channel n appears on `dac_codes[8n+7:8n]`.
- R2: A staging register changes only while `cs_n`, `en_n` and `rw_sel` are all low, and only for the addressed channel. Any other combination leaves every staging register unchanged.
- R3: While `ld_n` and `en_n` are both low, every code register takes its staging register's value, whatever the level of `cs_n`. At all other times every code register holds its value.
- R4: With `cs_n`, `en_n`, `ld_n` and `rw_sel` all low, bus data reaches the addressed code output with no other strobe. The new code is visible after the third rising edge that follows the pin change, and not after the second.
- R5: With `rw_sel` high, `cs_n` low and both `en_n` and `ld_n` high, `bus_oe` is high and `bus_out` carries the addressed staging register.
- R6: Once the aligned `cs_n` is high, `bus_oe` is low in that same cycle.
- R7: An active-low `rst_n` clears every staging and code register to 0x00 and drops `bus_oe`, and it overrides all other controls.
- R8: When a write and a load are active in the same cycle, the addressed code register takes the newly written value rather than the old staged one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| en_n | input | 1 | Active-low enable strobe |
| ld_n | input | 1 | Active-low load strobe for all code registers |
| rw_sel | input | 1 | 1 = read back, 0 = write |
| addr | input | 4 | Channel address |
| bus_in | input | 8 | Data from the host |
| bus_out | output | 8 | Readback data to the host |
| bus_oe | output | 1 | Drive enable for the bus |
| dac_codes | output | 128 | All sixteen code registers, channel 0 in the low byte |

## Verification
The assertions check several rules on every cycle. Staging registers hold outside an addressed write, and code registers hold outside a load. A load copies the staging rank, a concurrent write goes through to the code register, readback presents the addressed word one cycle after the request, and reset leaves all codes at zero. The bench scenarios show the rest. These cover double buffering across a stream of writes and loads, writes ignored because select or enable is inactive, the exact three-edge latency of the through path, readback across several addresses, bus release, and reset taking precedence while all strobes are active.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef struct packed {
    logic cs_n;
    logic en_n;
    logic ld_n;
    logic rw_sel;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int         W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dacfe_decode.sv
module dacfe_decode
  import dacfe_pkg::*;
(
  input  strobe_t s,
  output logic    wr_en,
  output logic    ld_en,
  output logic    rd_en
);
  always_comb begin
    wr_en = !s.cs_n && !s.en_n && !s.rw_sel;
    ld_en = !s.ld_n && !s.en_n;
    rd_en = !s.cs_n &&  s.rw_sel && s.en_n && s.ld_n;
  end
endmodule

// File: rtl/dacfe_regbank.sv
module dacfe_regbank #(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 8,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     ld_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_data,
  output logic [NUM_CH*CODE_W-1:0] stage_flat,
  output logic [NUM_CH*CODE_W-1:0] code_flat
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] code_q;
    logic              hit;
    logic [CODE_W-1:0] stage_nxt;

    assign hit       = wr_en && (wr_addr == ADDR_W'(i));
    assign stage_nxt = hit ? wr_data : stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        code_q  <= '0;
      end else begin
        stage_q <= stage_nxt;
        if (ld_en) code_q <= stage_nxt;
      end
    end

    assign stage_flat[i*CODE_W +: CODE_W] = stage_q;
    assign code_flat[i*CODE_W +: CODE_W]  = code_q;

    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(i)) |=> stage_flat[i*CODE_W +: CODE_W] == $past(stage_flat[i*CODE_W +: CODE_W]));

    assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ld_en && wr_addr == ADDR_W'(i)) |=> code_flat[i*CODE_W +: CODE_W] == $past(wr_data));
  end

  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(code_flat));

  assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !wr_en) |=> code_flat == $past(stage_flat));
endmodule

// File: rtl/dacfe_readback.sv
module dacfe_readback #(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 8,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     cs_n_al,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_CH*CODE_W-1:0] stage_flat,
  output logic [CODE_W-1:0]        bus_out,
  output logic                     bus_oe
);
  logic [CODE_W-1:0] word_sel;
  logic [CODE_W-1:0] out_q;
  logic              oe_q;

  always_comb begin
    word_sel = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rd_addr == ADDR_W'(k)) word_sel = stage_flat[k*CODE_W +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= rd_en ? word_sel : '0;
      oe_q  <= rd_en;
    end
  end

  assign bus_out = out_q;
  assign bus_oe  = oe_q && !cs_n_al;

  assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && !cs_n_al) |-> (bus_oe && bus_out == $past(stage_flat[rd_addr*CODE_W +: CODE_W]))
      or !$stable(stage_flat) or !$stable(rd_addr));
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 8,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     en_n,
  input  logic                     ld_n,
  input  logic                     rw_sel,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CODE_W-1:0]        bus_in,
  output logic [CODE_W-1:0]        bus_out,
  output logic                     bus_oe,
  output logic [NUM_CH*CODE_W-1:0] dac_codes
);
  localparam int AD_W = ADDR_W + CODE_W;

  strobe_t              raw_s;
  strobe_t              al_s;
  logic [STROBE_W-1:0]  al_bits;
  logic [AD_W-1:0]      al_ad;
  logic [ADDR_W-1:0]    al_addr;
  logic [CODE_W-1:0]    al_data;
  logic                 wr_en;
  logic                 ld_en;
  logic                 rd_en;
  logic [NUM_CH*CODE_W-1:0] stage_flat;

  assign raw_s = '{cs_n: cs_n, en_n: en_n, ld_n: ld_n, rw_sel: rw_sel};

  dacfe_sync #(.W(STROBE_W), .RST_VAL({STROBE_W{1'b1}})) u_sync_strobe (
    .clk(clk), .rst_n(rst_n), .d(raw_s), .q(al_bits)
  );

  dacfe_sync #(.W(AD_W), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({addr, bus_in}), .q(al_ad)
  );

  assign al_s    = strobe_t'(al_bits);
  assign al_addr = al_ad[AD_W-1 -: ADDR_W];
  assign al_data = al_ad[CODE_W-1:0];

  dacfe_decode u_decode (
    .s(al_s), .wr_en(wr_en), .ld_en(ld_en), .rd_en(rd_en)
  );

  dacfe_regbank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ld_en(ld_en),
    .wr_addr(al_addr), .wr_data(al_data),
    .stage_flat(stage_flat), .code_flat(dac_codes)
  );

  dacfe_readback #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .cs_n_al(al_s.cs_n),
    .rd_addr(al_addr), .stage_flat(stage_flat),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  assert_reset_clear_R7: assert property (@(posedge clk)
    !rst_n |-> (dac_codes == '0 && !bus_oe));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) && $past(cs_n, 3) |-> !bus_oe);
endmodule

// File: tb/dacfe_top_tb.sv
module dacfe_top_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cs_n, en_n, ld_n, rw_sel;
  logic [3:0]   addr;
  logic [7:0]   bus_in;
  logic [7:0]   bus_out;
  logic         bus_oe;
  logic [127:0] dac_codes;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dacfe_top u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .en_n(en_n), .ld_n(ld_n),
    .rw_sel(rw_sel), .addr(addr), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .dac_codes(dac_codes)
  );

  // entry: {cs_n, en_n, ld_n, rw_sel, addr[4], data[8], check_ch[4], expected[8]}
  localparam logic [27:0] VEC [11] = '{
    {4'b0010, 4'd0,  8'h11, 4'd0,  8'h00},  // R2/R3 staged only
    {4'b1110, 4'd0,  8'h00, 4'd0,  8'h00},  // R3 idle holds
    {4'b0010, 4'd5,  8'hA5, 4'd5,  8'h00},  // R2 staged only
    {4'b1000, 4'd0,  8'hFF, 4'd0,  8'h11},  // R3 load with select high
    {4'b1110, 4'd0,  8'h00, 4'd5,  8'hA5},  // R3 all channels loaded
    {4'b1010, 4'd3,  8'h77, 4'd3,  8'h00},  // R2 select high: no write
    {4'b1000, 4'd3,  8'h77, 4'd3,  8'h00},  // R2 load shows stage 3 untouched
    {4'b0110, 4'd7,  8'h33, 4'd7,  8'h00},  // R2 enable high: no write
    {4'b1000, 4'd0,  8'h00, 4'd7,  8'h00},  // R2 load shows stage 7 untouched
    {4'b0000, 4'd15, 8'hC3, 4'd15, 8'hC3},  // R4/R1/R8 through path
    {4'b1110, 4'd0,  8'h00, 4'd15, 8'hC3}   // R3 holds after through path
  };

  function automatic logic [7:0] code_of(input int ch);
    return dac_codes[ch*8 +: 8];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ctl, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    {cs_n, en_n, ld_n, rw_sel} = ctl;
    addr   = a;
    bus_in = d;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    {cs_n, en_n, ld_n, rw_sel} = 4'b1110;
    addr = '0; bus_in = '0;
    settle(3);
    check("R7 reset codes ch0", code_of(0), 8'h00);
    check("R7 reset codes ch15", code_of(15), 8'h00);
    check("R7 reset bus_oe", {7'd0, bus_oe}, 8'h00);
    rst_n = 1'b1;
    settle(2);

    for (int i = 0; i < 11; i++) begin
      drive(VEC[i][27:24], VEC[i][23:20], VEC[i][19:12]);
      settle(4);
      check($sformatf("R1/R2/R3 vector %0d ch%0d", i, VEC[i][11:8]),
            code_of(int'(VEC[i][11:8])), VEC[i][7:0]);
    end

    // R5 readback of several staging registers
    drive(4'b0111, 4'd5, 8'h00);
    settle(4);
    check("R5 readback oe", {7'd0, bus_oe}, 8'h01);
    check("R5 readback ch5", bus_out, 8'hA5);
    drive(4'b0111, 4'd15, 8'h00);
    settle(4);
    check("R5 readback ch15", bus_out, 8'hC3);
    drive(4'b0111, 4'd3, 8'h00);
    settle(4);
    check("R5 readback ch3 (ignored write)", bus_out, 8'h00);

    // R6 release on select high
    drive(4'b1111, 4'd3, 8'h00);
    settle(2);
    check("R6 bus released", {7'd0, bus_oe}, 8'h00);

    // R4 exact latency of through path
    drive(4'b0000, 4'd9, 8'h42);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 not yet after two edges", code_of(9), 8'h00);
    @(posedge clk);
    @(negedge clk);
    check("R4 visible after third edge", code_of(9), 8'h42);
    drive(4'b1110, 4'd0, 8'h00);
    settle(4);

    // R8/R1 write+load concurrent on one channel, others intact
    drive(4'b0000, 4'd2, 8'h5A);
    settle(4);
    drive(4'b1110, 4'd0, 8'h00);
    settle(4);
    check("R8 ch2 new value", code_of(2), 8'h5A);
    check("R1 ch5 unaffected", code_of(5), 8'hA5);
    check("R1 ch9 unaffected", code_of(9), 8'h42);

    // R7 reset overrides active strobes
    drive(4'b0000, 4'd2, 8'hEE);
    @(negedge clk);
    rst_n = 1'b0;
    settle(2);
    check("R7 reset overrides ch2", code_of(2), 8'h00);
    check("R7 reset clears ch5", code_of(5), 8'h00);
    {cs_n, en_n, ld_n, rw_sel} = 4'b1110;
    settle(1);
    rst_n = 1'b1;
    settle(4);
    check("R7 stays clear after reset ch0", code_of(0), 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule